// File: doc/BRIEF.md
# Host Ring Buffer Block Writer

This block takes a stream of data words, grouped into blocks by an end-of-block flag, and turns each word into a memory-write request aimed at a circular buffer in host memory. The write position advances one word per accepted request and wraps to the ring base at the end of the ring. When the last word of a block has been accepted, the block issues one more write request. That request carries the new write position and goes to a separate host control location, so host software learns of progress by polling memory instead of taking interrupts.

Two 32-bit register banks sit beside the engine. The host bank is written only by the host. It holds the enable, the ring base, the ring size, the host's read position and the control location. The status bank can be read by the host but is written only by the engine. It shows the last published write position and the number of completed blocks. The engine compares the host's read position with its own write position and stalls the input stream rather than overwrite words the host has not yet consumed.

The input stream and the write-request channel both use valid/ready. A data word passes straight through to the request channel in the same cycle. The input is therefore ready only when the request channel is ready, so back-pressure from memory reaches the source without delay. While the pointer write is pending, the input is held off. A source may drop `in_valid` before it is accepted. The engine makes no promise to keep a data request stable once its source stops offering the word.

Top module: `dmaring_writer`

## Requirements
- R1: After reset, `in_ready` and `wr_valid` are 0, and every register in both banks reads 0, so the engine starts disabled.
- R2: While bit 0 of host register 0 (enable) is 0, `in_ready` stays 0 and no data request is made.
- R3: In the data phase, when enabled and not full, `wr_valid` equals `in_valid`, `wr_data` equals `in_data`, and `in_ready` equals `wr_ready`. A word is written when `in_valid` and `in_ready` are both high in a cycle.
- R4: A data word goes to word address `base + wp`, where base is host register 1 and `wp` is the write offset. The ring holds 2^k words, with k taken from bits 4:0 of host register 2 and clamped to LOGMAX. `wp` starts at 0, advances by one per written word, and returns to 0 after offset 2^k-1.
- R5: In the cycle after the last word of a block (`in_last` high) is accepted, `wr_valid` is 1 and `wr_addr` is host register 4. `wr_data` holds the advanced `wp`, and `in_ready` stays 0 until that request is accepted.
- R6: With read offset r, taken as host register 3 modulo the ring size, the ring is full when (wp - r) mod 2^k equals 2^k-1. While the ring is full, `in_ready` is 0 and no data request is made.
- R7: Status register 0 reads the `wp` of the last accepted pointer write, and status register 1 reads the count of accepted pointer writes. Both change in the cycle after the pointer write is accepted. All other status registers read 0.
- R8: A host write with `hw_we` high stores `hw_wdata` at host register `hw_idx`, and the value is visible from the next cycle. `rd_data` is combinational: `rd_idx` bit 6 set selects the host bank, and bit 6 clear selects the status bank.
- R9: While a pointer write waits for `wr_ready`, `wr_valid` stays 1 and `wr_addr` and `wr_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | input word offered |
| in_ready | output | 1 | input word taken this cycle |
| in_data | input | DW | input word |
| in_last | input | 1 | word ends its block |
| wr_valid | output | 1 | write request offered |
| wr_ready | input | 1 | write request accepted |
| wr_addr | output | AW | word address of the request |
| wr_data | output | DW | data of the request |
| hw_we | input | 1 | host register write strobe |
| hw_idx | input | 6 | host register index |
| hw_wdata | input | 32 | host register write data |
| rd_idx | input | 7 | read index, bit 6 selects the bank |
| rd_data | output | 32 | read data |

## Verification
The data requests and `in_ready` respond in the same cycle as their inputs. The pointer request appears in the cycle after the last word is taken. The status registers and host registers change in the cycle after the handshake or write that causes them. The bench keeps a behavioural model that is advanced once per clock using the handshakes the requirements predict. Each cycle, it sets the inputs just after the falling edge, waits one time step, and compares every output with the model before the next rising edge. As a result, a same-cycle result is checked in that cycle, and a registered result is checked one cycle after its cause.

// File: rtl/dmaring_pkg.sv
package dmaring_pkg;
  typedef enum logic {PH_DATA = 1'b0, PH_PTR = 1'b1} phase_t;

  localparam int CFG_EN    = 0;
  localparam int CFG_BASE  = 1;
  localparam int CFG_LOG2  = 2;
  localparam int CFG_RDPTR = 3;
  localparam int CFG_CTRL  = 4;

  localparam int ST_WPTR = 0;
  localparam int ST_BLKS = 1;
endpackage

// File: rtl/dmaring_regs.sv
module dmaring_regs #(
  parameter int NREG = 64,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_we,
  input  logic [IW-1:0] hw_idx,
  input  logic [31:0]   hw_wdata,
  input  logic [IW:0]   rd_idx,
  input  logic [31:0]   st_wptr,
  input  logic [31:0]   st_blks,
  output logic [31:0]   rd_data,
  output logic [31:0]   cfg_en,
  output logic [31:0]   cfg_base,
  output logic [31:0]   cfg_log2,
  output logic [31:0]   cfg_rdptr,
  output logic [31:0]   cfg_ctrl
);
  import dmaring_pkg::*;

  logic [31:0] hreg [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) hreg[i] <= '0;
    end else if (hw_we) begin
      hreg[hw_idx] <= hw_wdata;
    end
  end

  assign cfg_en    = hreg[CFG_EN];
  assign cfg_base  = hreg[CFG_BASE];
  assign cfg_log2  = hreg[CFG_LOG2];
  assign cfg_rdptr = hreg[CFG_RDPTR];
  assign cfg_ctrl  = hreg[CFG_CTRL];

  always_comb begin
    if (rd_idx[IW]) begin
      rd_data = hreg[rd_idx[IW-1:0]];
    end else if (rd_idx[IW-1:0] == IW'(ST_WPTR)) begin
      rd_data = st_wptr;
    end else if (rd_idx[IW-1:0] == IW'(ST_BLKS)) begin
      rd_data = st_blks;
    end else begin
      rd_data = '0;
    end
  end
endmodule

// File: rtl/dmaring_pos.sv
module dmaring_pos #(
  parameter int AW     = 32,
  parameter int LOGMAX = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    log2_in,
  input  logic [AW-1:0] rdptr,
  input  logic          advance,
  output logic [AW-1:0] wp,
  output logic [AW-1:0] mask,
  output logic          full
);
  logic [4:0]    lg_eff;
  logic [AW-1:0] used;

  assign lg_eff = (log2_in > 5'(LOGMAX)) ? 5'(LOGMAX) : log2_in;
  assign mask   = (AW'(1) << lg_eff) - AW'(1);
  assign used   = (wp - rdptr) & mask;
  assign full   = (used == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       wp <= '0;
    else if (advance) wp <= (wp + AW'(1)) & mask;
  end

  // R4: the last slot of the ring is followed by slot 0
  p_wrap_to_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && wp == mask && $stable(mask)) |=> (wp == '0));
endmodule

// File: rtl/dmaring_writer.sv
module dmaring_writer #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NREG   = 64,
  parameter int LOGMAX = 20,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          hw_we,
  input  logic [IW-1:0] hw_idx,
  input  logic [31:0]   hw_wdata,
  input  logic [IW:0]   rd_idx,
  output logic [31:0]   rd_data
);
  import dmaring_pkg::*;

  phase_t        phase;
  logic [31:0]   cfg_en, cfg_base, cfg_log2, cfg_rdptr, cfg_ctrl;
  logic [31:0]   blk_cnt, pub_wp;
  logic [AW-1:0] wp, mask;
  logic          full, take, ptr_done, en;

  dmaring_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_we(hw_we), .hw_idx(hw_idx),
    .hw_wdata(hw_wdata), .rd_idx(rd_idx), .st_wptr(pub_wp),
    .st_blks(blk_cnt), .rd_data(rd_data), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_log2(cfg_log2), .cfg_rdptr(cfg_rdptr),
    .cfg_ctrl(cfg_ctrl)
  );

  dmaring_pos #(.AW(AW), .LOGMAX(LOGMAX)) u_pos (
    .clk(clk), .rst_n(rst_n), .log2_in(cfg_log2[4:0]),
    .rdptr(AW'(cfg_rdptr)), .advance(take), .wp(wp), .mask(mask),
    .full(full)
  );

  assign en       = cfg_en[0];
  assign in_ready = (phase == PH_DATA) && en && !full && wr_ready;
  assign take     = in_valid && in_ready;
  assign ptr_done = (phase == PH_PTR) && wr_ready;

  always_comb begin
    if (phase == PH_PTR) begin
      wr_valid = 1'b1;
      wr_addr  = AW'(cfg_ctrl);
      wr_data  = DW'(wp);
    end else begin
      wr_valid = in_valid && en && !full;
      wr_addr  = AW'(cfg_base) + wp;
      wr_data  = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_DATA;
      blk_cnt <= '0;
      pub_wp  <= '0;
    end else if (take && in_last) begin
      phase <= PH_PTR;
    end else if (ptr_done) begin
      phase   <= PH_DATA;
      blk_cnt <= blk_cnt + 32'd1;
      pub_wp  <= 32'(wp);
    end
  end

  // R2: disabled engine takes nothing
  p_off_no_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !in_ready);
  // R6: full ring stalls the input
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
  // R5: a block end is followed by the pointer request
  p_ptr_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> (wr_valid && !in_ready));
  // R9: a waiting pointer request holds steady
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PTR && !wr_ready && $stable(cfg_ctrl)) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R7: each accepted pointer write adds one block
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_done |=> (blk_cnt == $past(blk_cnt) + 32'd1));
endmodule

// File: tb/test_dmaring_writer.sv
module test_dmaring_writer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_last, wr_valid, wr_ready, hw_we;
  logic [31:0] in_data, wr_addr, wr_data, hw_wdata, rd_data;
  logic [5:0]  hw_idx;
  logic [6:0]  rd_idx;

  always #4 clk = ~clk;

  dmaring_writer i_dmaring_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_we(hw_we), .hw_idx(hw_idx), .hw_wdata(hw_wdata),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, drive_on = 0;
  logic [31:0] hreg [64];
  int mwp = 0, mphase = 0, mblocks = 0, mcommit = 0;
  logic [32:0] q [$];
  bit prev_ptr_wait = 0;
  int picks [8] = '{0, 1, 64, 65, 66, 67, 68, 2};

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push_block(int n, int seed);
    for (int i = 0; i < n; i++) q.push_back({(i == n - 1), 32'(seed + i)});
  endtask

  task automatic step();
    int lg, size, mask, base, rp, idx;
    bit en, full, exp_ir, exp_wv;
    logic [31:0] exp_addr, exp_data, exp_rd;
    in_valid = drive_on && (q.size() > 0) && (cyc % 7 != 2);
    {in_last, in_data} = (q.size() > 0) ? q[0] : 33'd0;
    wr_ready = (cyc % 5 != 3) && (cyc % 13 < 10);
    rd_idx   = 7'(picks[cyc % 8]);
    #1;
    en   = hreg[0][0];
    lg   = (hreg[2][4:0] > 20) ? 20 : int'(hreg[2][4:0]);
    size = 1 << lg;
    mask = size - 1;
    base = int'(hreg[1]);
    rp   = int'(hreg[3]) & mask;
    full = (((mwp - rp) & mask) == mask);
    if (mphase == 0) begin
      exp_ir   = en && !full && wr_ready;
      exp_wv   = in_valid && en && !full;
      exp_addr = 32'(base + mwp);
      exp_data = in_data;
      chk(!en ? "R2" : (full ? "R6" : "R3"), "in_ready", 32'(in_ready), 32'(exp_ir));
      chk(!en ? "R2" : (full ? "R6" : "R3"), "wr_valid", 32'(wr_valid), 32'(exp_wv));
      if (exp_wv) begin
        chk("R4", "data wr_addr", wr_addr, exp_addr);
        chk("R3", "data wr_data", wr_data, exp_data);
      end
    end else begin
      exp_addr = hreg[4];
      exp_data = 32'(mwp);
      chk(prev_ptr_wait ? "R9" : "R5", "ptr in_ready", 32'(in_ready), 32'd0);
      chk(prev_ptr_wait ? "R9" : "R5", "ptr wr_valid", 32'(wr_valid), 32'd1);
      chk(prev_ptr_wait ? "R9" : "R5", "ptr wr_addr", wr_addr, exp_addr);
      chk(prev_ptr_wait ? "R9" : "R5", "ptr wr_data", wr_data, exp_data);
      exp_ir = 0;
    end
    idx = picks[cyc % 8];
    if (idx >= 64)     exp_rd = hreg[idx - 64];
    else if (idx == 0) exp_rd = 32'(mcommit);
    else if (idx == 1) exp_rd = 32'(mblocks);
    else               exp_rd = 32'd0;
    chk(idx >= 64 ? "R8" : "R7", $sformatf("rd_data[%0d]", idx), rd_data, exp_rd);
    prev_ptr_wait = 0;
    if (mphase == 0 && in_valid && exp_ir) begin
      mwp = (mwp + 1) & mask;
      if (in_last) mphase = 1;
      void'(q.pop_front());
    end else if (mphase == 1) begin
      if (wr_ready) begin
        mphase  = 0;
        mblocks = mblocks + 1;
        mcommit = mwp;
      end else begin
        prev_ptr_wait = 1;
      end
    end
    if (hw_we) hreg[hw_idx] = hw_wdata;
    cyc++;
    @(negedge clk);
  endtask

  task automatic hwrite(int idx, logic [31:0] val);
    hw_we = 1'b1; hw_idx = 6'(idx); hw_wdata = val;
    step();
    hw_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) hreg[i] = '0;
    rst_n = 0; in_valid = 0; in_data = 0; in_last = 0; wr_ready = 1;
    hw_we = 0; hw_idx = 0; hw_wdata = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset in_ready", 32'(in_ready), 32'd0);
    chk("R1", "reset wr_valid", 32'(wr_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      rd_idx = 7'(picks[i]);
      #1 chk("R1", $sformatf("reset reg %0d", picks[i]), rd_data, 32'd0);
    end
    @(negedge clk);
    push_block(3, 32'hA000);
    push_block(2, 32'hA100);
    push_block(1, 32'hA200);
    push_block(2, 32'hA300);
    drive_on = 1;
    repeat (6) step();
    hwrite(1, 32'h1000);
    hwrite(2, 32'd3);
    hwrite(3, 32'd0);
    hwrite(4, 32'h80);
    hwrite(0, 32'd1);
    repeat (60) step();
    chk("R6", "stalled words left", 32'(q.size()), 32'd1);
    hwrite(3, 32'd4);
    push_block(4, 32'hB000);
    repeat (60) step();
    hwrite(3, 32'd3);
    push_block(5, 32'hC000);
    repeat (60) step();
    hwrite(3, 32'd6);
    repeat (40) step();
    hwrite(0, 32'd0);
    push_block(2, 32'hD000);
    repeat (20) step();
    chk("R2", "disabled words left", 32'(q.size()) > 0 ? 32'd1 : 32'd0, 32'd1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule